// File: doc/BRIEF.md
# Dual-Mode Serial Configuration Loader

This block is the configuration port of a sixteen-channel current-sink driver. A single serial stream (data, shift clock, latch strobe) fills one of two shift paths, and a mode level picks which one. With the mode level low, the stream fills a 16-bit path that carries one on/off bit per channel. With the mode level high, the stream fills a 112-bit path that carries a 7-bit brightness-correction word for every channel. Both paths shift most significant bit first. The serial output always shows the far end of the path that is selected, so several loaders can be chained, each one's output feeding the next one's input.

The strobe behaves differently in each mode. In on/off mode its rising edge copies the 16-bit path into the on/off register. In correction mode the correction register is transparent: it follows the 112-bit path while the strobe is high and keeps its value while the strobe is low. While it is transparent, shift-clock edges are discarded so that the register's contents stay still. The serial pins are asynchronous, so each one passes through a two-flop synchronizer into the system clock domain. A small state machine tracks the synchronized strobe and mode. It has three states. ST_SHIFT means the strobe is low and shifting is open. ST_PASS means the strobe is high in correction mode, the register is transparent and shifting is blocked. ST_HOLD means the strobe is high in on/off mode. The transitions are: ST_SHIFT to ST_PASS or ST_HOLD when the strobe rises (the ST_SHIFT to ST_HOLD transition loads the on/off register), ST_PASS and ST_HOLD back to ST_SHIFT when the strobe falls, and ST_PASS to ST_HOLD or back again when the mode changes while the strobe is high.

Top module: `cfg_serial_loader`

## Requirements
- R1: With mode low, the serial output equals bit 15 of the 16-bit path, so the first bit shifted in appears at the output after 16 shift-clock edges.
- R2: With mode high, the serial output equals bit 111 of the 112-bit path, and only that path shifts. The 16-bit path keeps its contents.
- R3: Each rising shift-clock edge moves the selected path up one place and puts the data bit into bit 0. A pin level sampled at system clock edge k takes effect at edge k+2.
- R4: The on/off register loads the 16-bit path only on a rising strobe edge taken with mode low. A strobe in correction mode leaves it unchanged.
- R5: The correction register copies the 112-bit path on every system clock edge while the state is ST_PASS, and holds its value otherwise.
- R6: Channel n's correction word occupies bits 7n+6 down to 7n, with bit 7n+6 as its most significant bit. Channel 15's word is therefore the first shifted in.
- R7: Channel n's on/off bit is bit n of the on/off register, so channel 15's bit is shifted in first.
- R8: Shift-clock edges that arrive while the state is ST_PASS change neither shift path nor the correction register.
- R9: A synchronous reset clears both shift paths, both registers and the serial output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_din | input | 1 | Serial data in, asynchronous |
| ser_clk | input | 1 | Serial shift clock, asynchronous, rising edge active |
| ser_latch | input | 1 | Latch strobe, asynchronous |
| mode_sel | input | 1 | Low selects the on/off path, high selects the correction path |
| ser_dout | output | 1 | Far end of the selected shift path |
| onoff_q | output | 16 | Per-channel on/off register, channel n in bit n |
| corr_q | output | 112 | Correction register, channel n in bits 7n+6..7n |

## Verification
On every cycle the assertions check several properties. The on/off register changes only after a strobe edge seen in on/off mode. The correction register changes only two clocks after a strobe-high, mode-high sample. Both shift paths are frozen while the state machine is in ST_PASS, and a shift moves the synchronized data bit into bit 0. Reset clears everything. Only the bench's scenarios can show the end-to-end results: the bit order across whole words, the channel packing of both registers, the serial output giving the first bit after a full load, and a correction strobe leaving the on/off register untouched. The bench does this by comparing against its own timed model of the synchronizer latency on every clock.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

    // Latch-control states of the loader
    typedef enum logic [1:0] {
        ST_SHIFT = 2'd0,  // strobe low, shifting open
        ST_PASS  = 2'd1,  // strobe high in correction mode, register transparent
        ST_HOLD  = 2'd2   // strobe high in on/off mode
    } ld_state_e;

    // Bit positions inside the synchronized pin bundle
    localparam int PIN_DIN   = 0;
    localparam int PIN_CLK   = 1;
    localparam int PIN_LATCH = 2;
    localparam int PIN_MODE  = 3;
    localparam int PIN_COUNT = 4;

endpackage

// File: rtl/cfg_pin_sync.sv
module cfg_pin_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] pin_s
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= pin_i;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign pin_s = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_latch_fsm.sv
module cfg_latch_fsm
    import cfg_loader_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      latch_s,
    input  logic      mode_s,
    output ld_state_e state,
    output logic      onoff_load,
    output logic      corr_follow,
    output logic      shift_block
);

    ld_state_e state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_SHIFT;
        end else begin
            state <= state_nx;
        end
    end

    // Next state and outputs
    always_comb begin
        state_nx    = state;
        onoff_load  = 1'b0;
        corr_follow = 1'b0;
        shift_block = 1'b0;
        unique case (state)
            ST_SHIFT: begin
                if (latch_s) begin
                    if (mode_s) begin
                        state_nx = ST_PASS;
                    end else begin
                        state_nx   = ST_HOLD;
                        onoff_load = 1'b1;
                    end
                end
            end
            ST_PASS: begin
                corr_follow = 1'b1;
                shift_block = 1'b1;
                if (!latch_s) begin
                    state_nx = ST_SHIFT;
                end else if (!mode_s) begin
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (!latch_s) begin
                    state_nx = ST_SHIFT;
                end else if (mode_s) begin
                    state_nx = ST_PASS;
                end
            end
            default: begin
                state_nx = ST_SHIFT;
            end
        endcase
    end

    // R5
    pass_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PASS) |-> ($past(latch_s) && $past(mode_s)));

    // R4
    hold_entry_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_SHIFT && state == ST_HOLD) |-> !$past(mode_s));

endmodule

// File: rtl/cfg_shift_path.sv
module cfg_shift_path #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] path_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q <= '0;
        end else if (shift_en) begin
            path_q <= {path_q[WIDTH-2:0], bit_in};
        end
    end

    // R3
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (path_q[0] == $past(bit_in)));

    // R2
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(path_q));

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int CH_COUNT  = 16,
    parameter int CORR_BITS = 7,
    parameter int SYNC_LEN  = 2
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ser_din,
    input  logic                          ser_clk,
    input  logic                          ser_latch,
    input  logic                          mode_sel,
    output logic                          ser_dout,
    output logic [CH_COUNT-1:0]           onoff_q,
    output logic [CH_COUNT*CORR_BITS-1:0] corr_q
);

    localparam int ON_W   = CH_COUNT;
    localparam int CORR_W = CH_COUNT * CORR_BITS;

    logic [PIN_COUNT-1:0] pin_raw;
    logic [PIN_COUNT-1:0] pin_s;
    logic                 din_s, clk_s, latch_s, mode_s;
    logic                 clk_d;
    logic                 clk_rise;
    ld_state_e            state;
    logic                 onoff_load, corr_follow, shift_block;
    logic                 en_on, en_corr;
    logic [ON_W-1:0]      sh_on;
    logic [CORR_W-1:0]    sh_corr;

    assign pin_raw[PIN_DIN]   = ser_din;
    assign pin_raw[PIN_CLK]   = ser_clk;
    assign pin_raw[PIN_LATCH] = ser_latch;
    assign pin_raw[PIN_MODE]  = mode_sel;

    cfg_pin_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_LEN)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (pin_raw),
        .pin_s (pin_s)
    );

    assign din_s   = pin_s[PIN_DIN];
    assign clk_s   = pin_s[PIN_CLK];
    assign latch_s = pin_s[PIN_LATCH];
    assign mode_s  = pin_s[PIN_MODE];

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_d <= 1'b0;
        end else begin
            clk_d <= clk_s;
        end
    end

    assign clk_rise = clk_s & ~clk_d;

    cfg_latch_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .latch_s     (latch_s),
        .mode_s      (mode_s),
        .state       (state),
        .onoff_load  (onoff_load),
        .corr_follow (corr_follow),
        .shift_block (shift_block)
    );

    assign en_on   = clk_rise & ~mode_s & ~shift_block;
    assign en_corr = clk_rise &  mode_s & ~shift_block;

    cfg_shift_path #(.WIDTH(ON_W)) u_path_on (
        .clk      (clk),
        .rst      (rst),
        .shift_en (en_on),
        .bit_in   (din_s),
        .path_q   (sh_on)
    );

    cfg_shift_path #(.WIDTH(CORR_W)) u_path_corr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (en_corr),
        .bit_in   (din_s),
        .path_q   (sh_corr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            onoff_q <= '0;
        end else if (onoff_load) begin
            onoff_q <= sh_on;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            corr_q <= '0;
        end else if (corr_follow) begin
            corr_q <= sh_corr;
        end
    end

    assign ser_dout = mode_s ? sh_corr[CORR_W-1] : sh_on[ON_W-1];

    // R4
    onoff_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(onoff_q) |-> ($past(latch_s) && !$past(mode_s)));

    // R5
    corr_when_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(corr_q) |-> ($past(latch_s, 2) && $past(mode_s, 2)));

    // R8
    pass_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_PASS) |-> ($stable(sh_corr) && $stable(sh_on)));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (onoff_q == '0 && corr_q == '0 && ser_dout == 1'b0));

endmodule

// File: tb/cfg_serial_loader_tb_top.sv
module cfg_serial_loader_tb_top;

    localparam int CH = 16;
    localparam int CB = 7;
    localparam int CW = CH * CB;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          din = 1'b0, sclk = 1'b0, lat = 1'b0, mode = 1'b0;
    logic          dout;
    logic [CH-1:0] onoff;
    logic [CW-1:0] corr;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    always #10 clk = ~clk;

    cfg_serial_loader dut_i (
        .clk       (clk),
        .rst       (rst),
        .ser_din   (din),
        .ser_clk   (sclk),
        .ser_latch (lat),
        .mode_sel  (mode),
        .ser_dout  (dout),
        .onoff_q   (onoff),
        .corr_q    (corr)
    );

    // Behavioural reference: pin history with two-clock latency
    logic [3:0]    hp1, hp2, hp3;   // {mode, lat, sclk, din}
    logic [CH-1:0] m16, mon;
    logic [CW-1:0] m112, mcorr;

    always @(posedge clk) begin
        logic          pass, rise;
        logic [CH-1:0] n16;
        logic [CW-1:0] n112;
        if (rst) begin
            hp1 = '0; hp2 = '0; hp3 = '0;
            m16 = '0; m112 = '0; mon = '0; mcorr = '0;
        end else begin
            pass = hp3[2] && hp3[3];
            rise = hp2[1] && !hp3[1];
            n16  = m16;
            n112 = m112;
            if (rise && !pass) begin
                if (hp2[3]) n112 = {m112[CW-2:0], hp2[0]};
                else        n16  = {m16[CH-2:0], hp2[0]};
            end
            if (hp2[2] && !hp3[2] && !hp2[3]) mon = m16;
            if (pass) mcorr = m112;
            m16  = n16;
            m112 = n112;
            hp3 = hp2;
            hp2 = hp1;
            hp1 = {mode, lat, sclk, din};
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic exp_dout;
            exp_dout = hp2[3] ? m112[CW-1] : m16[CH-1];
            checks++;
            if (dout !== exp_dout) begin
                fails++;
                $display("FAIL R1 R3 serial out actual=%0b expected=%0b t=%0t", dout, exp_dout, $time);
            end
            checks++;
            if (onoff !== mon) begin
                fails++;
                $display("FAIL R4 on/off actual=%h expected=%h t=%0t", onoff, mon, $time);
            end
            checks++;
            if (corr !== mcorr) begin
                fails++;
                $display("FAIL R5 correction actual=%h expected=%h t=%0t", corr, mcorr, $time);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        din = b;
        tick(3);
        sclk = 1'b1;
        tick(3);
        sclk = 1'b0;
        tick(2);
    endtask

    task automatic chk(input bit ok, input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [CB-1:0] wv(input int ch);
        return CB'((ch * 37 + 11) % 128);
    endfunction

    initial begin
        logic [CH-1:0] pat_a;
        logic [CH-1:0] pat_b;
        logic [CW-1:0] corr_img;
        pat_a = 16'hA5C3;
        pat_b = 16'h0F0F;
        tick(4);
        rst = 1'b0;
        tick(2);
        // R9: reset state
        chk(onoff == '0 && corr == '0 && dout == 1'b0, "R9 reset state",
            {dout, onoff, corr[CW-1:CH+1]}, '0);

        // On/off load, MSB first (R3, R7)
        mode = 1'b0;
        tick(4);
        for (int i = CH - 1; i >= 0; i--) send_bit(pat_a[i]);
        tick(4);
        // R1: first bit in is now at the serial output
        chk(dout == pat_a[CH-1], "R1 dout after 16 bits", CW'(dout), CW'(pat_a[CH-1]));
        lat = 1'b1; tick(6); lat = 1'b0; tick(6);
        // R4
        chk(onoff == pat_a, "R4 on/off load", CW'(onoff), CW'(pat_a));
        // R7: channel 0 in bit 0, channel 15 in bit 15
        chk(onoff[0] == 1'b1 && onoff[15] == 1'b1 && onoff[1] == 1'b1 && onoff[2] == 1'b0,
            "R7 channel bits", CW'(onoff), CW'(pat_a));

        // Correction load, channel 15 first (R2, R6)
        mode = 1'b1;
        tick(4);
        for (int ch = CH - 1; ch >= 0; ch--) begin
            for (int b = CB - 1; b >= 0; b--) send_bit(wv(ch)[b]);
        end
        tick(4);
        // R2: output shows bit 111 = MSB of channel 15's word
        chk(dout == wv(15)[CB-1], "R2 dout correction path", CW'(dout), CW'(wv(15)[CB-1]));
        chk(corr == '0, "R5 held before strobe", corr, '0);
        lat = 1'b1;
        tick(6);
        corr_img = '0;
        for (int ch = 0; ch < CH; ch++) corr_img[ch*CB +: CB] = wv(ch);
        // R5 and R6
        chk(corr == corr_img, "R5 R6 correction packing", corr, corr_img);
        chk(corr[CB-1:0] == wv(0) && corr[CW-1 -: CB] == wv(15), "R6 channel 0 and 15 words",
            {corr[CW-1 -: CB], corr[CB-1:0]}, {wv(15), wv(0)});
        // R8: shift clocks while transparent are discarded
        send_bit(1'b1);
        send_bit(1'b1);
        tick(2);
        lat = 1'b0;
        tick(6);
        chk(dout == wv(15)[CB-1], "R8 path frozen while transparent", CW'(dout), CW'(wv(15)[CB-1]));
        chk(corr == corr_img, "R8 correction unchanged", corr, corr_img);
        // R4: a correction-mode strobe left the on/off register alone
        chk(onoff == pat_a, "R4 on/off untouched by correction strobe", CW'(onoff), CW'(pat_a));

        // R5: register holds while new data shifts with strobe low
        for (int i = 0; i < 20; i++) send_bit(1'b0);
        tick(4);
        chk(corr == corr_img, "R5 hold with strobe low", corr, corr_img);

        // R2: back to on/off mode; the 16-bit path kept its contents
        mode = 1'b0;
        tick(4);
        chk(dout == pat_a[CH-1], "R2 16-bit path kept", CW'(dout), CW'(pat_a[CH-1]));
        for (int i = CH - 1; i >= 0; i--) send_bit(pat_b[i]);
        tick(4);
        lat = 1'b1; tick(6); lat = 1'b0; tick(6);
        chk(onoff == pat_b, "R4 second on/off load", CW'(onoff), CW'(pat_b));
        chk(corr == corr_img, "R2 correction kept in on/off mode", corr, corr_img);

        // R9: reset in mid-operation
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        chk(onoff == '0 && corr == '0 && dout == 1'b0, "R9 reset clears all",
            {dout, onoff, corr[CW-1:CH+1]}, '0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule